// File: doc/BRIEF.md
# Dual-Channel Performance Event Counter

This block sits next to a processor core and measures what the core is doing. It holds two counters of `CNT_W` bits, default 32. Each counter picks one line out of a bank of `2**CODE_W` event inputs, default 256, using an 8-bit code. A counter runs in one of two modes. In occurrence mode it counts each new assertion of the chosen line. In stall mode it counts every cycle in which the line is held high.

Counting is qualified by the privilege level the core reports. Each counter has a user enable and a supervisor enable, and a single global power bit gates all counting. A chain bit joins the two counters into one wider count: the lower counter's wrap feeds the upper counter. A counter that wraps does so silently, and the block raises no interrupt.

Software reaches the block through a plain register bus. The bus has a write strobe, a byte address, write data and combinational read data. Register 0x0 is control, 0x4 is counter 0 and 0x8 is counter 1. The bus carries single register accesses rather than a data stream, so it has no valid/ready handshake and no back-pressure: every write is taken on the clock edge where `reg_wr` is high.

Top module: `dual_event_counter`

## Requirements
- R1: A synchronous active-high reset clears the control register and both counters, so all three registers read 0.
- R2: When a counter's mode bit is 1 (occurrence mode), the counter adds one for each 0-to-1 transition of its selected event line. A level held for several cycles counts once.
- R3: When a counter's mode bit is 0 (stall mode), the counter adds one on every clock edge at which its selected event line is high.
- R4: A counter follows only the event line whose index equals its 8-bit code. Activity on all other lines has no effect on it.
- R5: A counter advances only when the privilege level matches one of its enables. `priv_super`=1 is supervisor and uses the supervisor enable; `priv_super`=0 is user and uses the user enable.
- R6: Control bit 0 is the power bit. While it is 0, neither counter changes except by a bus write, and all other control fields keep their stored values.
- R7: With control bit 31 (chain) set, counter 1 ignores its own event line. It adds one exactly when counter 0 increments from all-ones to zero.
- R8: With chain clear, a counter at all-ones wraps to zero on its next count. The other counter does not change, and no interrupt exists.
- R9: A bus write to a counter in the same cycle as an increment stores the written value, and the increment is lost.
- R10: Control layout: bit 0 power; bits [8:1] counter-0 code; bit 9 counter-0 mode; bit 10 counter-0 user enable; bit 11 counter-0 supervisor enable. The same four fields for counter 1 sit at bits [19:12], 20, 21 and 22. Bit 31 is chain. All other bits read 0, so writing all-ones reads back 0x807FFFFF. Misaligned or unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address: 0x0 control, 0x4 counter 0, 0x8 counter 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_in | input | 256 | Event lines from the core, indexed by event code |
| priv_super | input | 1 | 1 when the core runs in supervisor mode, 0 in user mode |

## Verification
Every count is due one clock edge after the cycle in which its qualifying event level is presented. A write, likewise, is visible on `reg_rdata` one edge after the cycle in which the strobe is held. In stall mode an event high for N cycles therefore adds N. In occurrence mode the same stimulus adds the number of rising edges, counted from a line that started low. The bench drives events and strobes at the falling edge and reads at a later falling edge, after the last edge that could have counted. For the write-priority case it reads on the first falling edge after the write and again one edge later, where the value has grown by exactly one.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int CODE_W  = 8;
  localparam int NUM_EVT = 1 << CODE_W;
  localparam int NUM_CH  = 2;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;

  // one channel's control fields, LSB first: code, mode, user, supervisor
  typedef struct packed {
    logic              sup_en;
    logic              user_en;
    logic              occ_mode;
    logic [CODE_W-1:0] code;
  } chan_cfg_t;

  localparam int CFG_W       = $bits(chan_cfg_t);
  localparam int POWER_BIT   = 0;
  localparam int CH_BASE     = 1;
  localparam int CHAIN_BIT   = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADR_CTL = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_C0  = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_C1  = 4'h8;

  function automatic logic [DATA_W-1:0] ctl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[POWER_BIT] = 1'b1;
    m[CHAIN_BIT] = 1'b1;
    for (int c = 0; c < NUM_CH; c++)
      for (int b = 0; b < CFG_W; b++)
        m[CH_BASE + c*CFG_W + b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dec_event_sel.sv
module dec_event_sel
  import dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  chan_cfg_t          cfg,
  input  logic               priv_super,
  input  logic               power,
  output logic               hit
);
  logic sel;
  logic prev_q;
  logic priv_ok;
  logic cond;

  assign sel     = evt_in[cfg.code];
  assign priv_ok = priv_super ? cfg.sup_en : cfg.user_en;
  assign cond    = cfg.occ_mode ? (sel & ~prev_q) : sel;
  assign hit     = power & priv_ok & cond;

  // last sampled level of the selected line, kept up to date at all times
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel;
  end
endmodule

// File: rtl/dec_counter.sv
module dec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             carry
);
  assign carry = inc & ~wr_en & (&count);

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= wr_val;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
  import dec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               priv_super
);
  localparam logic [DATA_W-1:0] MASK = ctl_mask();

  logic [DATA_W-1:0] ctl_q;
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] inc;
  logic [NUM_CH-1:0] carry;
  logic [NUM_CH-1:0] cnt_wr;
  logic              wr_ctl;
  logic              power;
  logic              chain;

  assign wr_ctl = reg_wr && (reg_addr == ADR_CTL);
  assign power  = ctl_q[POWER_BIT];
  assign chain  = ctl_q[CHAIN_BIT];

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= reg_wdata & MASK;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg       = ctl_q[CH_BASE + g*CFG_W +: CFG_W];
    assign cnt_wr[g] = reg_wr && (reg_addr == ADR_C0 + ADDR_W'(4*g));

    dec_event_sel u_sel (
      .clk        (clk),
      .rst        (rst),
      .evt_in     (evt_in),
      .cfg        (cfg),
      .priv_super (priv_super),
      .power      (power),
      .hit        (hit[g])
    );

    if (g == 0) begin : g_low
      assign inc[g] = hit[g];
    end else begin : g_up
      // chained: the next-lower counter's wrap replaces this channel's event
      assign inc[g] = chain ? carry[g-1] : hit[g];
    end

    dec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cnt_wr[g]),
      .wr_val (reg_wdata[CNT_W-1:0]),
      .inc    (inc[g]),
      .count  (cnt_q[g]),
      .carry  (carry[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_CTL)     reg_rdata = ctl_q;
    else if (reg_addr == ADR_C0) reg_rdata = DATA_W'(cnt_q[0]);
    else if (reg_addr == ADR_C1) reg_rdata = DATA_W'(cnt_q[1]);
  end
endmodule

// File: rtl/dec_checker.sv
module dec_checker
  import dec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] ctl,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1
);
  logic w0, w1;
  assign w0 = reg_wr && (reg_addr == ADR_C0);
  assign w1 = reg_wr && (reg_addr == ADR_C1);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ctl == '0 && cnt0 == '0 && cnt1 == '0));

  // R6
  a_r6_power_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl[POWER_BIT] && !w0) |=> cnt0 == $past(cnt0));

  // R9
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    w0 |=> cnt0 == $past(reg_wdata[CNT_W-1:0]));

  // R3 / R2: without a write a counter moves by at most one
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !w1 |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + 1'b1));

  // R7
  a_r7_chain_carry: assert property (@(posedge clk) disable iff (rst)
    (ctl[CHAIN_BIT] && !w1) |=>
      (cnt1 == $past(cnt1) || ($past(cnt0) == '1 && cnt0 == '0)));
endmodule

bind dual_event_counter dec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ctl       (ctl_q),
  .cnt0      (cnt_q[0]),
  .cnt1      (cnt_q[1])
);

// File: tb/test_dual_event_counter.sv
`timescale 1ns/1ps
module test_dual_event_counter;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = 4'h0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] evt_in = '0;
  logic         priv_super = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_event_counter i_dual_event_counter (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .priv_super(priv_super)
  );

  function automatic logic [31:0] cfg(int ch, int code, bit mode, bit usr, bit sup);
    logic [31:0] f;
    f = {21'd0, sup, usr, mode, code[7:0]};
    return f << (1 + ch*11);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic hold_evt(input int idx, input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk); evt_in[idx] = 1'b1;
    end
    @(negedge clk); evt_in = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", 4'h0, 0); chk("R1", 4'h4, 0); chk("R1", 4'h8, 0);

    // R10 layout and masking
    wr(4'h0, 32'hFFFF_FFFF);
    chk("R10", 4'h0, 32'h807F_FFFF);
    chk("R10", 4'h2, 32'h0);
    wr(4'h0, 32'h0);

    // R2 R3 R4 sweep: codes, modes, channels with noise on the other lines
    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int ch = 0; ch < 2; ch++) begin
          int code;
          logic [15:0] pat;
          int expv;
          bit prev;
          code = (i == 7) ? 255 : i * 37;
          pat  = 16'hB35A ^ 16'(i * 16'h1111) ^ 16'(m * 16'h0F0F);
          wr(4'h0, 32'h1 | cfg(ch, code, m[0], 1'b1, 1'b1));
          wr(4'h4, 0); wr(4'h8, 0);
          expv = 0; prev = 1'b0;
          for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            evt_in = ~('1 << 0);
            evt_in = '1;
            evt_in[code] = pat[t];
            if (m == 1) expv += (pat[t] && !prev) ? 1 : 0;
            else        expv += pat[t] ? 1 : 0;
            prev = pat[t];
          end
          @(negedge clk); evt_in = '0;
          chk(m ? "R2" : "R3", ch ? 4'h8 : 4'h4, expv);
          chk("R4", ch ? 4'h4 : 4'h8, 0);
        end
      end
    end

    // R5 privilege qualification
    wr(4'h0, 32'h1 | cfg(0, 2, 1'b0, 1'b1, 1'b0));
    wr(4'h4, 0);
    priv_super = 1'b1; hold_evt(2, 4);
    chk("R5", 4'h4, 0);
    priv_super = 1'b0; hold_evt(2, 4);
    chk("R5", 4'h4, 4);
    wr(4'h0, 32'h1 | cfg(0, 2, 1'b0, 1'b0, 1'b1));
    hold_evt(2, 4);
    chk("R5", 4'h4, 4);
    priv_super = 1'b1; hold_evt(2, 4);
    chk("R5", 4'h4, 8);

    // R6 power gating keeps fields
    wr(4'h0, cfg(0, 6, 1'b0, 1'b1, 1'b1));
    wr(4'h4, 0);
    hold_evt(6, 5);
    chk("R6", 4'h4, 0);
    chk("R6", 4'h0, cfg(0, 6, 1'b0, 1'b1, 1'b1));
    wr(4'h0, 32'h1 | cfg(0, 6, 1'b0, 1'b1, 1'b1));
    hold_evt(6, 3);
    chk("R6", 4'h4, 3);

    // R9 write beats a simultaneous increment
    wr(4'h0, 32'h1 | cfg(0, 5, 1'b0, 1'b1, 1'b1));
    @(negedge clk); evt_in[5] = 1'b1;
    wr(4'h4, 100);
    chk("R9", 4'h4, 100);
    @(negedge clk);
    chk("R9", 4'h4, 101);
    evt_in = '0;

    // R7 chain carry
    wr(4'h0, 32'h8000_0001 | cfg(0, 3, 1'b0, 1'b1, 1'b1) | cfg(1, 3, 1'b0, 1'b1, 1'b1));
    wr(4'h4, 32'hFFFF_FFFE); wr(4'h8, 5);
    hold_evt(3, 3);
    chk("R7", 4'h4, 1);
    chk("R7", 4'h8, 6);

    // R8 silent wrap without chain
    wr(4'h0, 32'h1 | cfg(1, 9, 1'b0, 1'b1, 1'b1));
    wr(4'h8, 32'hFFFF_FFFF); wr(4'h4, 7);
    hold_evt(9, 1);
    chk("R8", 4'h8, 0);
    chk("R8", 4'h4, 7);

    // R1 reset again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1", 4'h0, 0); chk("R1", 4'h8, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule